// File: doc/BRIEF.md
# I2C Bus Clock and Edge Timing Generator

This block produces the serial clock of an I2C master and marks the cycles at which the transfer engine may move or read the data line. The engine asks for one bus phase at a time: a data bit, a START or a STOP. The block plays out that phase's clock waveform and raises single-cycle strobes at the SDA change point and at the SDA sample point. A one-cycle completion pulse tells the engine when it may ask for the next phase.

Every SCL half-period is built from eight sub-periods. The low half uses one 16-bit divider and the high half uses another, so each half is eight times its divider plus one, counted in input clocks. Three small tuning fields scale the data-change point and the START and STOP setup times in whole multiples of those dividers. The divider word and the tuning byte are captured only when a phase is accepted. Writing new values while a phase is in flight therefore never bends a bus cycle. A build parameter swaps the START timing for an older fixed-ratio form.

Top module: `i2c_scl_timegen`

## Requirements
- R1: After reset, `scl` is high and `ready` is high, with `done`, `sda_upd` and `sda_smp` low.
- R2: A request is taken on a clock edge where `req_valid` and `ready` are both high. Kind code 0 (and 3) asks for a data bit: SCL is low for 8·(divl+1) cycles and then high for 8·(divh+1) cycles. `divl` is `clk_div[15:0]` and `divh` is `clk_div[31:16]`.
- R3: In the low part of a data bit, `sda_upd` pulses in low cycle index (divl+1)·s, where the first low cycle is index 0 and s = `tune[3:0]`+1.
- R4: In the high part of a data bit, `sda_smp` pulses in high cycle index 4·(divh+1), which is the middle of the high time.
- R5: Kind code 1 is START and expects SCL high. SCL stays high and `sda_upd` pulses 8·h·u+1 cycles after acceptance, with h = divh+1 and u = `tune[5:4]`+1. SCL then falls, and `done` rises, 8·h·(u+1)−1 cycles after that pulse.
- R6: Kind code 2 is STOP. SCL is low for 8·l cycles (l = divl+1), with `sda_upd` at low index l·s. SCL then rises, and `sda_upd` pulses again 8·h·p+1 cycles later, with p = `tune[7:6]`+1. After that, `ready` stays low for a further 8·(l+h) bus-free cycles before `done`.
- R7: `clk_div` and `tune` are sampled only on the accepting edge. Changing them during a phase leaves that phase's timing unchanged.
- R8: With the START variant parameter set, START holds SCL high for 16·h cycles and the SDA-change pulse comes 7·h cycles after acceptance, whatever the tuning fields hold.
- R9: `done` is a one-cycle pulse in the first idle cycle after a phase. A `req_valid` seen while `ready` is low starts nothing.
- R10: Values of `tune[3:0]` from 6 to 15 all give s = 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_div | input | 32 | High divider in [31:16], low divider in [15:0] |
| tune | input | 8 | [3:0] data-change scale, [5:4] START setup scale, [7:6] STOP setup scale |
| req_valid | input | 1 | Phase request |
| req_kind | input | 2 | 0 bit, 1 START, 2 STOP, 3 bit |
| ready | output | 1 | Idle, a request is accepted this cycle |
| done | output | 1 | One-cycle phase completion pulse |
| scl | output | 1 | Serial clock level |
| sda_upd | output | 1 | SDA may change at this cycle |
| sda_smp | output | 1 | SDA should be sampled at this cycle |

## Verification
A wrong segment state or segment counter shows up at the ports as an SCL edge, a strobe or a `done` pulse landing on the wrong cycle. The bench predicts every such event to the exact cycle from the captured configuration, so a fault is reported no later than the end of the segment it corrupts. A shadow value that follows the live inputs instead of the accepting edge shifts the next strobe of the same phase, because the bench scrambles the inputs right after acceptance.

// File: rtl/i2c_tg_pkg.sv
package i2c_tg_pkg;
   typedef enum logic [2:0] {
      SG_IDLE = 3'd0,
      SG_LOW  = 3'd1,
      SG_HIGH = 3'd2,
      SG_SSU  = 3'd3,
      SG_SHD  = 3'd4,
      SG_PLOW = 3'd5,
      SG_PSU  = 3'd6,
      SG_FREE = 3'd7
   } seg_e;

   localparam logic [1:0] KIND_BIT   = 2'd0;
   localparam logic [1:0] KIND_START = 2'd1;
   localparam logic [1:0] KIND_STOP  = 2'd2;
endpackage

// File: rtl/i2c_tg_shadow.sv
module i2c_tg_shadow #(
   parameter int DIV_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [2*DIV_W-1:0] clk_div,
   input  logic [7:0]         tune,
   output logic [DIV_W:0]     l_val,
   output logic [DIV_W:0]     h_val,
   output logic [2:0]         s_val,
   output logic [2:0]         u_val,
   output logic [2:0]         p_val
);
   localparam logic [DIV_W:0] ONE = (DIV_W+1)'(1);

   // settings are frozen at phase acceptance (R7)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         l_val <= ONE;
         h_val <= ONE;
         s_val <= 3'd1;
         u_val <= 3'd1;
         p_val <= 3'd1;
      end else if (load) begin
         l_val <= {1'b0, clk_div[DIV_W-1:0]} + ONE;
         h_val <= {1'b0, clk_div[2*DIV_W-1:DIV_W]} + ONE;
         s_val <= (tune[3:0] >= 4'd6) ? 3'd7 : (tune[2:0] + 3'd1);   // R10 clamp
         u_val <= {1'b0, tune[5:4]} + 3'd1;
         p_val <= {1'b0, tune[7:6]} + 3'd1;
      end
   end
endmodule

// File: rtl/i2c_tg_seglen.sv
module i2c_tg_seglen
   import i2c_tg_pkg::*;
#(
   parameter int DIV_W        = 16,
   parameter int LEN_W        = DIV_W + 7,
   parameter bit LEGACY_START = 1'b0
) (
   input  seg_e             seg,
   input  logic [DIV_W:0]   l_val,
   input  logic [DIV_W:0]   h_val,
   input  logic [2:0]       s_val,
   input  logic [2:0]       u_val,
   input  logic [2:0]       p_val,
   output logic [LEN_W-1:0] seg_len,
   output logic [LEN_W-1:0] upd_pt,
   output logic [LEN_W-1:0] smp_pt
);
   localparam int LW = LEN_W;

   logic [LW-1:0] lx, hx, l8, h8, ssu_len, shd_len, psu_len;

   assign lx      = LW'(l_val);
   assign hx      = LW'(h_val);
   assign l8      = lx << 3;
   assign h8      = hx << 3;
   assign psu_len = h8 * LW'(p_val) + LW'(1);

   generate
      if (LEGACY_START) begin : g_legacy
         assign ssu_len = hx * LW'(7);
         assign shd_len = hx * LW'(9);
      end else begin : g_tuned
         assign ssu_len = h8 * LW'(u_val) + LW'(1);
         assign shd_len = h8 * (LW'(u_val) + LW'(1)) - LW'(1);
      end
   endgenerate

   always_comb begin
      case (seg)
         SG_LOW, SG_PLOW: seg_len = l8;
         SG_HIGH:         seg_len = h8;
         SG_SSU:          seg_len = ssu_len;
         SG_SHD:          seg_len = shd_len;
         SG_PSU:          seg_len = psu_len;
         SG_FREE:         seg_len = l8 + h8;
         default:         seg_len = LW'(1);
      endcase
   end

   assign upd_pt = lx * LW'(s_val);
   assign smp_pt = hx << 2;
endmodule

// File: rtl/i2c_tg_seq.sv
module i2c_tg_seq
   import i2c_tg_pkg::*;
#(
   parameter int LEN_W = 23
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [1:0]       req_kind,
   input  logic [LEN_W-1:0] seg_len,
   input  logic [LEN_W-1:0] upd_pt,
   input  logic [LEN_W-1:0] smp_pt,
   output seg_e             seg,
   output logic             accept,
   output logic             ready,
   output logic             done,
   output logic             scl,
   output logic             sda_upd,
   output logic             sda_smp
);
   logic [LEN_W-1:0] cnt;
   seg_e             seg_nxt;
   logic             last, scl_nxt;

   assign ready  = (seg == SG_IDLE);
   assign accept = ready && req_valid;
   assign last   = !ready && (cnt == seg_len - LEN_W'(1));

   always_comb begin
      seg_nxt = seg;
      if (accept) begin
         case (req_kind)
            KIND_START: seg_nxt = SG_SSU;
            KIND_STOP:  seg_nxt = SG_PLOW;
            default:    seg_nxt = SG_LOW;
         endcase
      end else if (last) begin
         case (seg)
            SG_LOW:  seg_nxt = SG_HIGH;
            SG_SSU:  seg_nxt = SG_SHD;
            SG_PLOW: seg_nxt = SG_PSU;
            SG_PSU:  seg_nxt = SG_FREE;
            default: seg_nxt = SG_IDLE;
         endcase
      end
   end

   always_comb begin
      scl_nxt = scl;
      if (accept || last) begin
         case (seg_nxt)
            SG_LOW, SG_PLOW: scl_nxt = 1'b0;
            SG_HIGH, SG_PSU: scl_nxt = 1'b1;
            SG_IDLE:         scl_nxt = (seg == SG_SHD) ? 1'b0 : scl;
            default:         scl_nxt = scl;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seg  <= SG_IDLE;
         cnt  <= '0;
         scl  <= 1'b1;
         done <= 1'b0;
      end else begin
         seg  <= seg_nxt;
         cnt  <= (accept || last || ready) ? '0 : cnt + LEN_W'(1);
         scl  <= scl_nxt;
         done <= last && (seg_nxt == SG_IDLE);
      end
   end

   assign sda_upd = (((seg == SG_LOW) || (seg == SG_PLOW)) && (cnt == upd_pt)) ||
                    (((seg == SG_SHD) || (seg == SG_FREE)) && (cnt == '0));
   assign sda_smp = (seg == SG_HIGH) && (cnt == smp_pt);
endmodule

// File: rtl/i2c_scl_timegen.sv
module i2c_scl_timegen
   import i2c_tg_pkg::*;
#(
   parameter int DIV_W        = 16,
   parameter bit LEGACY_START = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [2*DIV_W-1:0] clk_div,
   input  logic [7:0]         tune,
   input  logic               req_valid,
   input  logic [1:0]         req_kind,
   output logic               ready,
   output logic               done,
   output logic               scl,
   output logic               sda_upd,
   output logic               sda_smp
);
   localparam int LEN_W = DIV_W + 7;

   generate
      if (DIV_W < 2 || DIV_W > 24) begin : g_bad_div
         $error("i2c_scl_timegen: DIV_W out of supported range");
      end
   endgenerate

   seg_e             seg;
   logic             accept;
   logic [DIV_W:0]   l_val, h_val;
   logic [2:0]       s_val, u_val, p_val;
   logic [LEN_W-1:0] seg_len, upd_pt, smp_pt;

   i2c_tg_shadow #(.DIV_W(DIV_W)) shadow_i (
      .clk(clk), .rst_n(rst_n), .load(accept), .clk_div(clk_div), .tune(tune),
      .l_val(l_val), .h_val(h_val), .s_val(s_val), .u_val(u_val), .p_val(p_val)
   );

   i2c_tg_seglen #(.DIV_W(DIV_W), .LEN_W(LEN_W), .LEGACY_START(LEGACY_START)) seglen_i (
      .seg(seg), .l_val(l_val), .h_val(h_val), .s_val(s_val), .u_val(u_val),
      .p_val(p_val), .seg_len(seg_len), .upd_pt(upd_pt), .smp_pt(smp_pt)
   );

   i2c_tg_seq #(.LEN_W(LEN_W)) seq_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
      .seg_len(seg_len), .upd_pt(upd_pt), .smp_pt(smp_pt), .seg(seg),
      .accept(accept), .ready(ready), .done(done), .scl(scl),
      .sda_upd(sda_upd), .sda_smp(sda_smp)
   );
endmodule

// File: rtl/i2c_scl_timegen_chk.sv
module i2c_scl_timegen_chk (
   input logic clk,
   input logic rst_n,
   input logic ready,
   input logic done,
   input logic scl,
   input logic sda_upd,
   input logic sda_smp
);
   p_done_in_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ready);

   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(sda_upd && sda_smp));

   p_smp_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
      sda_smp |-> (scl && !ready));

   p_rise_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(scl) |-> !ready);
endmodule

bind i2c_scl_timegen i2c_scl_timegen_chk chk_i (
   .clk(clk), .rst_n(rst_n), .ready(ready), .done(done),
   .scl(scl), .sda_upd(sda_upd), .sda_smp(sda_smp)
);

// File: tb/i2c_scl_timegen_tb_top.sv
`timescale 1ns/1ps
module i2c_scl_timegen_tb_top;
   localparam int EV_FALL = 0, EV_RISE = 1, EV_UPD = 2, EV_SMP = 3, EV_DONE = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] clk_div = '0;
   logic [7:0]  tune = '0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_kind = '0;
   logic        ready, done, scl, sda_upd, sda_smp;

   logic [31:0] lg_div = '0;
   logic        lg_req = 1'b0;
   logic        lg_ready, lg_done, lg_scl, lg_upd, lg_smp;

   always #2.5 clk = ~clk;

   i2c_scl_timegen dut_i (
      .clk(clk), .rst_n(rst_n), .clk_div(clk_div), .tune(tune),
      .req_valid(req_valid), .req_kind(req_kind), .ready(ready), .done(done),
      .scl(scl), .sda_upd(sda_upd), .sda_smp(sda_smp)
   );

   i2c_scl_timegen #(.LEGACY_START(1'b1)) dut_leg_i (
      .clk(clk), .rst_n(rst_n), .clk_div(lg_div), .tune(8'hFF),
      .req_valid(lg_req), .req_kind(2'd1), .ready(lg_ready), .done(lg_done),
      .scl(lg_scl), .sda_upd(lg_upd), .sda_smp(lg_smp)
   );

   typedef struct {
      int     k;
      longint c;
      string  r;
   } ev_t;

   ev_t    q[$];
   longint cyc = 0;
   int     total = 0;
   int     bad = 0;
   bit     exp_scl = 1'b1;
   bit     prev_scl = 1'b1;
   bit     mon_on = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(bit ok, string r, string what, longint act, longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", r, what, act, exp);
      end
   endtask

   task automatic push(int k, longint c, string r);
      ev_t e;
      e.k = k; e.c = c; e.r = r;
      q.push_back(e);
   endtask

   task automatic got(int k);
      ev_t e;
      if (q.size() == 0) begin
         chk(1'b0, "R9", $sformatf("unexpected event kind %0d at cycle", k), cyc, -1);
      end else begin
         e = q.pop_front();
         chk(e.k == k && e.c == cyc, e.r,
             $sformatf("event kind %0d (expected kind %0d) cycle", k, e.k), cyc, e.c);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (mon_on) begin
         if (prev_scl && !scl) got(EV_FALL);
         if (!prev_scl && scl) got(EV_RISE);
         if (sda_upd)          got(EV_UPD);
         if (sda_smp)          got(EV_SMP);
         if (done)             got(EV_DONE);
         while (q.size() > 0 && q[0].c <= cyc) begin
            chk(1'b0, q[0].r, $sformatf("missing event kind %0d at cycle", q[0].k), cyc, q[0].c);
            void'(q.pop_front());
         end
      end
      prev_scl = scl;
   end

   // driver: one phase, expectations pushed from the requirement formulas
   task automatic do_phase(logic [1:0] kind, int dl, int dh, int sf, int uf, int pf);
      longint a, l, h, s, u, p, t;
      @(negedge clk);
      while (!ready) @(negedge clk);
      clk_div   = {dh[15:0], dl[15:0]};
      tune      = {pf[1:0], uf[1:0], sf[3:0]};
      req_kind  = kind;
      req_valid = 1'b1;
      a = cyc + 1;
      l = dl + 1; h = dh + 1; u = uf + 1; p = pf + 1;
      s = (sf >= 6) ? 7 : sf + 1;
      if (kind == 2'd1) begin
         t = a + 8*h*u + 1;
         push(EV_UPD, t, "R5");
         push(EV_FALL, t + 8*h*(u+1) - 1, "R5");
         push(EV_DONE, t + 8*h*(u+1) - 1, "R5");
         exp_scl = 1'b0;
      end else if (kind == 2'd2) begin
         if (exp_scl) push(EV_FALL, a, "R6");
         push(EV_UPD, a + l*s, (sf >= 6) ? "R10" : "R6");
         push(EV_RISE, a + 8*l, "R6");
         t = a + 8*l + 8*h*p + 1;
         push(EV_UPD, t, "R6");
         push(EV_DONE, t + 8*(l+h), "R6");
         exp_scl = 1'b1;
      end else begin
         if (exp_scl) push(EV_FALL, a, "R2");
         push(EV_UPD, a + l*s, (sf >= 6) ? "R10" : "R3");
         push(EV_RISE, a + 8*l, "R2");
         push(EV_SMP, a + 8*l + 4*h, "R4");
         push(EV_DONE, a + 8*l + 8*h, "R7");
         exp_scl = 1'b1;
      end
      @(negedge clk);
      // R7: scramble the settings while the phase runs
      req_valid = 1'b0;
      clk_div   = ~clk_div;
      tune      = ~tune;
      @(negedge clk);
      // R9: a request while busy must start nothing
      req_kind  = 2'd2;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   always @(posedge clk) begin
      if (cyc > 100000) begin
         total++;
         bad++;
         $display("FAIL R9 watchdog expired actual=%0d expected=%0d", cyc, 0);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      longint a, upd_c, done_c;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(scl == 1'b1,     "R1", "scl after reset", scl, 1);
      chk(ready == 1'b1,   "R1", "ready after reset", ready, 1);
      chk(done == 1'b0,    "R1", "done after reset", done, 0);
      chk(sda_upd == 1'b0, "R1", "sda_upd after reset", sda_upd, 0);
      chk(sda_smp == 1'b0, "R1", "sda_smp after reset", sda_smp, 0);
      mon_on = 1'b1;

      do_phase(2'd1, 2, 1, 2, 1, 2);
      do_phase(2'd0, 2, 1, 2, 1, 2);
      do_phase(2'd3, 2, 1, 2, 1, 2);
      do_phase(2'd2, 2, 1, 2, 1, 2);

      do_phase(2'd1, 0, 0, 9, 3, 0);
      do_phase(2'd0, 0, 0, 15, 3, 0);
      do_phase(2'd2, 0, 0, 6, 3, 0);

      do_phase(2'd1, 5, 3, 0, 0, 3);
      do_phase(2'd0, 5, 3, 0, 0, 3);
      do_phase(2'd2, 5, 3, 0, 0, 3);

      @(negedge clk);
      while (!ready) @(negedge clk);
      repeat (4) @(negedge clk);
      chk(q.size() == 0, "R9", "events left in scoreboard", q.size(), 0);
      chk(scl == 1'b1, "R6", "scl idle after stop", scl, 1);

      // R8: fixed-ratio START variant, divh=3 so h=4
      lg_div = {16'd3, 16'd0};
      lg_req = 1'b1;
      a = cyc + 1;
      @(negedge clk);
      lg_req = 1'b0;
      upd_c = -1; done_c = -1;
      for (int i = 0; i < 300 && done_c < 0; i++) begin
         if (lg_upd && upd_c < 0) upd_c = cyc;
         if (lg_done) done_c = cyc;
         @(negedge clk);
      end
      chk(upd_c == a + 28, "R8", "legacy start sda change cycle", upd_c, a + 28);
      chk(done_c == a + 64, "R8", "legacy start done cycle", done_c, a + 64);
      chk(lg_scl == 1'b0, "R8", "legacy scl after start", lg_scl, 0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule